// File: doc/BRIEF.md
# Daisy-Chained Serial Control and Fault Interface

This block is the digital control core of a six-channel low-side gate predriver. A serial port (active-low select, shift clock, data in, and a data out modelled as a value plus an output enable) loads per-channel on/off commands. Over the same port it returns a snapshot of the fault status. A six-bit parallel input can also switch channels on with no clock or select activity. The enable driven to each gate is the OR of the latched serial command and the parallel input. Any battery fault forces every gate off.

All port inputs are sampled into a fast system clock. The select and shift clock are synchronized and edge-detected there. Every device in a cascade takes exactly eight bits per frame, and received data leaves the data output after the device's own eight fault bits. An active-low fault flag summarizes the captured status. Capture is frozen while the device is selected, and it is cleared and re-armed when the device is deselected.

Top module: `gate_predrive_ctrl`

## Requirements
- R1: When `sel_n` falls, `sdo_oe` goes to 1 and the shift register is loaded with the current fault word. While `sel_n` is high, `sdo_oe` is 0.
- R2: Each rising edge of `sclk` shifts `sdi` into the LSB. `sdo_data` always presents the register MSB. The fault word is bit 7 = over-battery, bit 6 = under-battery, and bits 5..0 = load fault of channels 5..0, where 1 means fault. The first bit out is bit 7.
- R3: While selected, later changes of the status inputs neither change the shifted word nor change `flt_n`.
- R4: When `sel_n` rises, the six most recently received bits go to the command latch. The last bit received drives channel 0, and the sixth-last drives channel 5. The latch resets to all channels off.
- R5: In a frame longer than 8 bits, each bit appears on `sdo_data` exactly 8 shifts after it entered.
- R6: `gate_en[i]` is 1 when command bit i or `par_in[i]` is 1. The parallel path needs no `sclk` or `sel_n` activity.
- R7: While `over_bat` or `under_bat` is 1, every bit of `gate_en` is 0. Normal drive returns when both are 0.
- R8: While a battery fault is present, the load-fault bits are reported as 0, both in the captured word and in the flag.
- R9: `flt_n` is 0 exactly when the captured fault register holds a set bit. While deselected, that register follows the live status. On deselect it is cleared and then re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data in |
| sdo_data | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Serial data out enable (0 = high impedance) |
| par_in | input | 6 | Parallel channel-on inputs |
| load_fault | input | 6 | Per-channel load fault status |
| over_bat | input | 1 | Over-battery status |
| under_bat | input | 1 | Under-battery status |
| gate_en | output | 6 | Gate enable per channel |
| flt_n | output | 1 | Active-low fault flag |

## Verification
The hardest state to reach is a selected frame in which the status inputs change after the snapshot was taken. The word that is shifted out must then differ from the live status, and `flt_n` must hold its refreshed value. The bench gets there by first raising a load fault and selecting the device. It then clears that fault and raises another one mid-frame, reads the word out, deselects, and watches the flag recover. Cascade pass-through is reached with a 16-bit frame whose first byte must reappear on the output during the second byte.

// File: rtl/gpd_pkg.sv
package gpd_pkg;
  typedef struct packed {
    logic selected;
    logic selFall;
    logic selRise;
    logic shiftPulse;
  } gpd_strobe_t;
endpackage

// File: rtl/gpd_ctrl.sv
module gpd_ctrl
  import gpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        selNIn,
  input  logic        sclkIn,
  input  logic        sdiIn,
  output gpd_strobe_t strobe,
  output logic        sdiSync
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] selChain;
  logic [SYNC_STAGES-1:0] sclkChain;
  logic [SYNC_STAGES-1:0] sdiChain;
  logic selPrev;
  logic sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selChain  <= '1;
      sclkChain <= '0;
      sdiChain  <= '0;
      selPrev   <= 1'b1;
      sclkPrev  <= 1'b0;
    end else begin
      selChain  <= {selChain[SYNC_STAGES-2:0], selNIn};
      sclkChain <= {sclkChain[SYNC_STAGES-2:0], sclkIn};
      sdiChain  <= {sdiChain[SYNC_STAGES-2:0], sdiIn};
      selPrev   <= selChain[LAST];
      sclkPrev  <= sclkChain[LAST];
    end
  end

  always_comb begin
    strobe.selected   = ~selChain[LAST];
    strobe.selFall    = ~selChain[LAST] & selPrev;
    strobe.selRise    = selChain[LAST] & ~selPrev;
    strobe.shiftPulse = sclkChain[LAST] & ~sclkPrev;
  end

  assign sdiSync = sdiChain[LAST];
endmodule

// File: rtl/gpd_datapath.sv
module gpd_datapath
  import gpd_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  gpd_strobe_t       strobe,
  input  logic              sdiSync,
  input  logic [NUM_CH-1:0] loadFault,
  input  logic              overBat,
  input  logic              underBat,
  input  logic [NUM_CH-1:0] parIn,
  output logic [NUM_CH-1:0] gateEn,
  output logic              sdoData,
  output logic              fltN
);
  localparam int FRAME_W = NUM_CH + 2;

  logic              batBad;
  logic [FRAME_W-1:0] faultLive;
  logic [FRAME_W-1:0] faultReg;
  logic [FRAME_W-1:0] shiftReg;
  logic [NUM_CH-1:0]  cmdLatch;

  assign batBad    = overBat | underBat;
  assign faultLive = {overBat, underBat, batBad ? '0 : loadFault};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.selFall) begin
      shiftReg <= faultLive;
    end else if (strobe.selected && strobe.shiftPulse) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], sdiSync};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultReg <= '0;
    end else if (strobe.selFall) begin
      faultReg <= faultLive;
    end else if (strobe.selRise) begin
      faultReg <= '0;
    end else if (!strobe.selected) begin
      faultReg <= faultLive;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdLatch <= '0;
    end else if (strobe.selRise) begin
      cmdLatch <= shiftReg[NUM_CH-1:0];
    end
  end

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_gate
      assign gateEn[ch] = (cmdLatch[ch] | parIn[ch]) & ~batBad;
    end
  endgenerate

  assign sdoData = shiftReg[FRAME_W-1];
  assign fltN    = ~|faultReg;
endmodule

// File: rtl/gate_predrive_ctrl.sv
module gate_predrive_ctrl #(
  parameter int NUM_CH      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo_data,
  output logic              sdo_oe,
  input  logic [NUM_CH-1:0] par_in,
  input  logic [NUM_CH-1:0] load_fault,
  input  logic              over_bat,
  input  logic              under_bat,
  output logic [NUM_CH-1:0] gate_en,
  output logic              flt_n
);
  gpd_pkg::gpd_strobe_t strobe;
  logic sdiSync;

  gpd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rst_n), .selNIn(sel_n), .sclkIn(sclk), .sdiIn(sdi),
    .strobe(strobe), .sdiSync(sdiSync)
  );

  gpd_datapath #(.NUM_CH(NUM_CH)) dp_i (
    .clk(clk), .rstN(rst_n), .strobe(strobe), .sdiSync(sdiSync),
    .loadFault(load_fault), .overBat(over_bat), .underBat(under_bat),
    .parIn(par_in), .gateEn(gate_en), .sdoData(sdo_data), .fltN(flt_n)
  );

  assign sdo_oe = strobe.selected;
endmodule

// File: rtl/gate_predrive_ctrl_checker.sv
module gate_predrive_ctrl_checker #(
  parameter int NUM_CH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdo_oe,
  input logic [NUM_CH-1:0] par_in,
  input logic              over_bat,
  input logic              under_bat,
  input logic [NUM_CH-1:0] gate_en,
  input logic              flt_n
);
  p_gate_off_bat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (over_bat || under_bat) |-> (gate_en == '0));

  p_par_drives_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!over_bat && !under_bat) |-> ((par_in & ~gate_en) == '0));

  p_flag_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && $past(sdo_oe, 2)) |-> $stable(flt_n));

  p_bat_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdo_oe && !$past(sdo_oe) && !$past(sdo_oe, 2) && over_bat &&
     $past(over_bat) && $past(over_bat, 2)) |-> !flt_n);
endmodule

bind gate_predrive_ctrl gate_predrive_ctrl_checker #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .sdo_oe(sdo_oe), .par_in(par_in),
  .over_bat(over_bat), .under_bat(under_bat), .gate_en(gate_en), .flt_n(flt_n)
);

// File: tb/gate_predrive_ctrl_tb_top.sv
module gate_predrive_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo_data, sdo_oe, flt_n;
  logic [5:0] par_in = '0, load_fault = '0, gate_en;
  logic over_bat = 1'b0, under_bat = 1'b0;
  int nChecks = 0, nFails = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_predrive_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .sdo_data(sdo_data), .sdo_oe(sdo_oe), .par_in(par_in),
    .load_fault(load_fault), .over_bat(over_bat), .under_bat(under_bat),
    .gate_en(gate_en), .flt_n(flt_n)
  );

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic selectDev();
    sel_n = 1'b0;
    waitClk(6);
  endtask

  task automatic deselectDev();
    sel_n = 1'b1;
    waitClk(6);
  endtask

  // shifts nBits of din (MSB first), returns the bits seen on sdo before each rise
  task automatic xfer(input logic [15:0] din, input int nBits, output logic [15:0] dout);
    dout = '0;
    for (int i = nBits - 1; i >= 0; i--) begin
      sdi = din[i];
      waitClk(HALF_SCLK);
      dout[i] = sdo_data;
      sclk = 1'b1;
      waitClk(HALF_SCLK);
      sclk = 1'b0;
    end
  endtask

  task automatic testReset();
    check(gate_en == 6'h00, "R4 reset cmd off", {10'h0, gate_en}, 16'h0);
    check(sdo_oe == 1'b0, "R1 oe low deselected", {15'h0, sdo_oe}, 16'h0);
    check(flt_n == 1'b1, "R9 flag idle", {15'h0, flt_n}, 16'h1);
  endtask

  task automatic testParallel();
    par_in = 6'b000101;
    #1;
    check(gate_en == 6'b000101, "R6 parallel no clock", {10'h0, gate_en}, 16'h05);
    par_in = 6'b110000;
    #1;
    check(gate_en == 6'b110000, "R6 parallel pattern2", {10'h0, gate_en}, 16'h30);
    par_in = '0;
    waitClk(1);
  endtask

  task automatic testFrame();
    logic [15:0] got;
    load_fault = 6'b100010;
    waitClk(4);
    check(flt_n == 1'b0, "R9 flag tracks live", {15'h0, flt_n}, 16'h0);
    selectDev();
    check(sdo_oe == 1'b1, "R1 oe on select", {15'h0, sdo_oe}, 16'h1);
    xfer(16'h002C, 8, got);
    check(got[7:0] == 8'b0010_0010, "R2 fault word order", got, 16'h22);
    deselectDev();
    check(sdo_oe == 1'b0, "R1 oe off after deselect", {15'h0, sdo_oe}, 16'h0);
    check(gate_en == 6'b101100, "R4 last six bits latched", {10'h0, gate_en}, 16'h2C);
    par_in = 6'b000001;
    #1;
    check(gate_en == 6'b101101, "R6 serial OR parallel", {10'h0, gate_en}, 16'h2D);
    par_in = '0;
    load_fault = '0;
    waitClk(4);
  endtask

  task automatic testFreeze();
    logic [15:0] got;
    load_fault = 6'b000001;
    waitClk(4);
    selectDev();
    load_fault = 6'b010000;
    waitClk(4);
    check(flt_n == 1'b0, "R3 flag frozen while selected", {15'h0, flt_n}, 16'h0);
    xfer(16'h0000, 8, got);
    check(got[7:0] == 8'h01, "R3 snapshot word", got, 16'h01);
    load_fault = '0;
    waitClk(4);
    check(flt_n == 1'b0, "R3 flag still frozen", {15'h0, flt_n}, 16'h0);
    deselectDev();
    check(flt_n == 1'b1, "R9 cleared on deselect", {15'h0, flt_n}, 16'h1);
    check(gate_en == 6'h00, "R4 zero frame turns off", {10'h0, gate_en}, 16'h0);
  endtask

  task automatic testBattery();
    logic [15:0] got;
    selectDev();
    xfer(16'h003F, 8, got);
    deselectDev();
    par_in = 6'h3F;
    load_fault = 6'b001100;
    over_bat = 1'b1;
    waitClk(4);
    check(gate_en == 6'h00, "R7 over-battery gates off", {10'h0, gate_en}, 16'h0);
    check(flt_n == 1'b0, "R9 battery flag", {15'h0, flt_n}, 16'h0);
    selectDev();
    xfer(16'h003F, 8, got);
    deselectDev();
    check(got[7:0] == 8'h80, "R8 over-battery masks load", got, 16'h80);
    over_bat = 1'b0;
    under_bat = 1'b1;
    waitClk(4);
    check(gate_en == 6'h00, "R7 under-battery gates off", {10'h0, gate_en}, 16'h0);
    selectDev();
    xfer(16'h003F, 8, got);
    deselectDev();
    check(got[7:0] == 8'h40, "R8 under-battery masks load", got, 16'h40);
    under_bat = 1'b0;
    par_in = '0;
    waitClk(4);
    check(gate_en == 6'h3F, "R7 resume after clear", {10'h0, gate_en}, 16'h3F);
    check(flt_n == 1'b0, "R8 load fault reported again", {15'h0, flt_n}, 16'h0);
    load_fault = '0;
    waitClk(4);
  endtask

  task automatic testCascade();
    logic [15:0] got;
    selectDev();
    xfer(16'hA512, 16, got);
    deselectDev();
    check(got[7:0] == 8'hA5, "R5 pass-through after 8", got, 16'hA5);
    check(got[15:8] == 8'h00, "R5 own fault bits first", got, 16'h00);
    check(gate_en == 6'b010010, "R4 cascade latch", {10'h0, gate_en}, 16'h12);
  endtask

  initial begin
    waitClk(3);
    rst_n = 1'b1;
    waitClk(3);
    testReset();
    testParallel();
    testFrame();
    testFreeze();
    testBattery();
    testCascade();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule